// File: doc/BRIEF.md
# Third-Order Fractional-N Divide-Value Modulator

This block drives a multi-modulus prescaler in a fractional-N synthesizer. Once per reference cycle it emits an instantaneous divide value. The long-run mean of that value equals 64 plus the programmed integer word plus the fractional word over 5200. Three cascaded error-feedback accumulators wrap at 5200 rather than at a power of two. Their carries are merged through a noise-cancelling difference network, so the quantisation error is pushed to high offset frequencies.

A pseudo-random bit from a 15-bit shift register can be added to the least significant bit of the first accumulator's input. This breaks up the periodic patterns that short fractional cycles produce. The final value is limited to the legal prescaler range 64 to 127, and a flag marks any cycle where that limit had to act. All state advances only on cycles where the reference-rate enable is high.

Top module: `fnsdm_mod`

## Requirements
- R1: While reset is asserted and after it releases, before the first enabled update, `div_out` is 64 and `div_clamped` is 0.
- R2: On a cycle where `ref_en` is low, `div_out`, `div_clamped` and all modulator state keep their values, so the output sequence resumes unchanged when `ref_en` returns high.
- R3: With `frac_word` equal to 0 and dither off, every update produces exactly 64 + `int_word`.
- R4: With dither off and no limiting, the sum of the first 5200 outputs after reset differs from 5200·(64 + `int_word`) + `frac_word` by at most 2.
- R5: From reset with `frac_word` = 2600 and dither off, the offsets from 64 + `int_word` are 0 on the first update, then repeat +2, −1, +1, 0 with period 4.
- R6: The offset applied to 64 + `int_word` on each update lies between −3 and +4.
- R7: When 64 + `int_word` + offset exceeds 127, `div_out` is 127 and `div_clamped` is 1 for that update.
- R8: When 64 + `int_word` + offset is below 64, `div_out` is 64 and `div_clamped` is 1 for that update.
- R9: `div_clamped` is 0 on every update whose unlimited value lies within 64 to 127.
- R10: A `frac_word` above 5199 acts as 5199.
- R11: With `dither_en` high, a shift-register bit is added to the first stage input on each update. The output sequence then departs from the undithered sequence, but stays within 64 to 127.
- R12: Each accumulator residue stays below 5200.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_en | input | 1 | One-cycle strobe per reference period; advances the modulator |
| int_word | input | 6 | Integer part of the division ratio above 64 |
| frac_word | input | 13 | Fractional numerator over 5200 |
| dither_en | input | 1 | Adds a pseudo-random bit to the first stage input |
| div_out | output | 7 | Divide value for the prescaler, limited to 64..127 |
| div_clamped | output | 1 | High when the current value was limited |

## Verification
A corrupted accumulator residue or carry delay register shows up at `div_out` on the very next enabled update. It either breaks the fixed four-step offset pattern for a half-step fraction, or it shifts the 5200-update running sum by at least one count. A stuck or mistimed delay stage in the cancelling network shows up as an offset outside −3..+4, or as a wrong value within the first five updates. A lost enable gate is exposed within one cycle of a hold window, because the output moves while it should stay frozen.

// File: rtl/fnsdm_pkg.sv
package fnsdm_pkg;
  // offset produced by the noise-cancelling network, signed
  localparam int OFFS_W   = 5;
  localparam int OFFS_LO  = -3;
  localparam int OFFS_HI  = 4;
  localparam int N_STAGES = 3;

  typedef logic signed [OFFS_W-1:0] offs_t;
endpackage

// File: rtl/fnsdm_stage.sv
module fnsdm_stage #(
  parameter int MOD = 5200,
  parameter int W   = $clog2(MOD)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W:0]   in_val,
  output logic         carry,
  output logic [W-1:0] resid
);
  localparam logic [W:0] MOD_V = (W+1)'(MOD);

  logic [W-1:0] acc_q, acc_d;
  logic [W:0]   sum;

  always_comb begin
    sum   = {1'b0, acc_q} + in_val;
    carry = (sum >= MOD_V);
    resid = carry ? W'(sum - MOD_V) : W'(sum);
    acc_d = en ? resid : acc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  p_acc_range_r12: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q < W'(MOD));
  p_acc_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(acc_q));
endmodule

// File: rtl/fnsdm_lfsr.sv
module fnsdm_lfsr #(
  parameter int          W    = 15,
  parameter int          TAP  = 13,
  parameter logic [W-1:0] SEED = W'(1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic bit_o
);
  logic [W-1:0] q, d;
  logic         fb;

  always_comb begin
    fb    = q[W-1] ^ q[TAP];
    d     = en ? {q[W-2:0], fb} : q;
    bit_o = q[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= SEED;
    else        q <= d;
  end

  p_lfsr_alive_r11: assert property (@(posedge clk) disable iff (!rst_n)
    q != '0);
endmodule

// File: rtl/fnsdm_cancel.sv
module fnsdm_cancel
  import fnsdm_pkg::*;
#(
  parameter int INT_W   = 6,
  parameter int OUT_W   = 7,
  parameter int DIV_MIN = 64,
  parameter int DIV_MAX = 127
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             c1,
  input  logic             c2,
  input  logic             c3,
  input  logic [INT_W-1:0] int_word,
  output logic [OUT_W-1:0] div_q,
  output logic             clamp_q
);
  localparam int RAW_W = OUT_W + 2;
  localparam logic signed [RAW_W-1:0] LO = RAW_W'(DIV_MIN);
  localparam logic signed [RAW_W-1:0] HI = RAW_W'(DIV_MAX);

  logic c2_q, c3_q, c3_qq;
  logic c2_d, c3_d, c3_dd;
  offs_t off;
  logic signed [RAW_W-1:0] raw;
  logic [OUT_W-1:0] div_d;
  logic             clamp_d;

  always_comb begin
    off = OFFS_W'(c1) + OFFS_W'(c2) - OFFS_W'(c2_q)
        + OFFS_W'(c3) - OFFS_W'({c3_q, 1'b0}) + OFFS_W'(c3_qq);
    raw = LO + RAW_W'(int_word) + RAW_W'(off);
    c2_d   = c2_q;
    c3_d   = c3_q;
    c3_dd  = c3_qq;
    div_d  = div_q;
    clamp_d = clamp_q;
    if (en) begin
      c2_d  = c2;
      c3_d  = c3;
      c3_dd = c3_q;
      if (raw > HI) begin
        div_d   = OUT_W'(DIV_MAX);
        clamp_d = 1'b1;
      end else if (raw < LO) begin
        div_d   = OUT_W'(DIV_MIN);
        clamp_d = 1'b1;
      end else begin
        div_d   = OUT_W'(raw);
        clamp_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c2_q    <= 1'b0;
      c3_q    <= 1'b0;
      c3_qq   <= 1'b0;
      div_q   <= OUT_W'(DIV_MIN);
      clamp_q <= 1'b0;
    end else begin
      c2_q    <= c2_d;
      c3_q    <= c3_d;
      c3_qq   <= c3_dd;
      div_q   <= div_d;
      clamp_q <= clamp_d;
    end
  end

  p_offs_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (off >= OFFS_W'(OFFS_LO)) && (off <= OFFS_W'(OFFS_HI)));
  p_out_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(div_q) && $stable(clamp_q)));
  p_out_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q >= OUT_W'(DIV_MIN)) && (div_q <= OUT_W'(DIV_MAX)));
  p_clamp_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_q |-> (div_q == OUT_W'(DIV_MIN) || div_q == OUT_W'(DIV_MAX)));
endmodule

// File: rtl/fnsdm_mod.sv
module fnsdm_mod
  import fnsdm_pkg::*;
#(
  parameter int FRAC_MOD  = 5200,
  parameter int INT_W     = 6,
  parameter int OUT_W     = 7,
  parameter int DIV_MIN   = 64,
  parameter int DIV_MAX   = 127,
  parameter int LFSR_W    = 15,
  parameter int LFSR_TAP  = 13,
  parameter int FRAC_W    = $clog2(FRAC_MOD)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_en,
  input  logic [INT_W-1:0]  int_word,
  input  logic [FRAC_W-1:0] frac_word,
  input  logic              dither_en,
  output logic [OUT_W-1:0]  div_out,
  output logic              div_clamped
);
  localparam logic [FRAC_W-1:0] FRAC_TOP = FRAC_W'(FRAC_MOD - 1);

  logic [FRAC_W-1:0] frac_sat;
  logic              dith_bit;
  logic [N_STAGES-1:0] carry;
  logic [FRAC_W-1:0]   resid [N_STAGES];
  logic [FRAC_W:0]     stage_in [N_STAGES];

  always_comb begin
    frac_sat = (frac_word > FRAC_TOP) ? FRAC_TOP : frac_word;
  end

  fnsdm_lfsr #(.W(LFSR_W), .TAP(LFSR_TAP), .SEED(LFSR_W'(1))) u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (ref_en),
    .bit_o (dith_bit)
  );

  for (genvar g = 0; g < N_STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      assign stage_in[g] = {1'b0, frac_sat} + (FRAC_W+1)'(dither_en & dith_bit);
    end else begin : g_next
      assign stage_in[g] = {1'b0, resid[g-1]};
    end
    fnsdm_stage #(.MOD(FRAC_MOD), .W(FRAC_W)) u_acc (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (ref_en),
      .in_val (stage_in[g]),
      .carry  (carry[g]),
      .resid  (resid[g])
    );
  end

  fnsdm_cancel #(
    .INT_W(INT_W), .OUT_W(OUT_W), .DIV_MIN(DIV_MIN), .DIV_MAX(DIV_MAX)
  ) u_cancel (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (ref_en),
    .c1       (carry[0]),
    .c2       (carry[1]),
    .c3       (carry[2]),
    .int_word (int_word),
    .div_q    (div_out),
    .clamp_q  (div_clamped)
  );

  p_last_resid_r12: assert property (@(posedge clk) disable iff (!rst_n)
    resid[N_STAGES-1] < FRAC_W'(FRAC_MOD));
  p_first_in_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stage_in[0] <= (FRAC_W+1)'(FRAC_MOD));
endmodule

// File: tb/fnsdm_mod_tb.sv
module fnsdm_mod_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ref_en;
  logic [5:0] int_word;
  logic [12:0] frac_word;
  logic       dither_en;
  logic [6:0] div_out;
  logic       div_clamped;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fnsdm_mod u_dut (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .int_word(int_word),
    .frac_word(frac_word), .dither_en(dither_en),
    .div_out(div_out), .div_clamped(div_clamped)
  );

  localparam int NV = 6;
  localparam int V_INT  [NV] = '{10, 20, 30, 5, 40, 50};
  localparam int V_FRAC [NV] = '{0, 1, 2600, 5199, 1234, 4321};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic start(input int n, input int f, input bit d);
    @(negedge clk);
    rst_n = 1'b0; ref_en = 1'b0;
    @(negedge clk);
    int_word = 6'(n); frac_word = 13'(f); dither_en = d;
    rst_n = 1'b1; ref_en = 1'b1;
  endtask

  // offset of update k (k from 1) for the half-step fraction
  function automatic int half_off(input int k);
    int pat [4] = '{2, -1, 1, 0};
    if (k == 1) return 0;
    return pat[(k-2) % 4];
  endfunction

  initial begin
    int cap [32];
    rst_n = 1'b0; ref_en = 1'b0; int_word = '0; frac_word = '0; dither_en = 1'b0;
    repeat (3) @(negedge clk);
    check(div_out == 7'd64, "R1 reset value", div_out, 64);
    check(div_clamped == 1'b0, "R1 reset flag", div_clamped, 0);

    // vector table: running-sum test
    for (int v = 0; v < NV; v++) begin
      longint sum;
      longint expv;
      start(V_INT[v], V_FRAC[v], 1'b0);
      sum = 0;
      for (int k = 0; k < 5200; k++) begin
        @(negedge clk);
        sum += div_out;
        if (V_FRAC[v] == 0 && k < 40)
          check(div_out == 7'(64 + V_INT[v]), "R3 constant output", div_out, 64 + V_INT[v]);
      end
      expv = 5200 * (64 + V_INT[v]) + V_FRAC[v];
      check((sum - expv) >= -2 && (sum - expv) <= 2, "R4 average ratio", int'(sum), int'(expv));
    end

    // pattern, upper and lower limiting
    for (int t = 0; t < 3; t++) begin
      int n;
      n = (t == 0) ? 30 : (t == 1) ? 63 : 0;
      start(n, 2600, 1'b0);
      for (int k = 1; k <= 12; k++) begin
        int raw, e;
        bit ce;
        @(negedge clk);
        raw = 64 + n + half_off(k);
        e = (raw > 127) ? 127 : (raw < 64) ? 64 : raw;
        ce = (raw > 127) || (raw < 64);
        if (t == 0) check(div_out == 7'(e), "R5 offset pattern", div_out, e);
        else if (t == 1) check(div_out == 7'(e), "R7 upper limit", div_out, e);
        else check(div_out == 7'(e), "R8 lower limit", div_out, e);
        check(div_clamped == ce, "R9 clamp flag", div_clamped, int'(ce));
        check(raw - 64 - n >= -3 && raw - 64 - n <= 4, "R6 offset span", raw - 64 - n, 0);
      end
      if (t == 0) begin
        logic [6:0] held;
        held = div_out;
        ref_en = 1'b0;
        for (int h = 0; h < 5; h++) begin
          @(negedge clk);
          check(div_out == held, "R2 hold value", div_out, held);
        end
        ref_en = 1'b1;
        for (int k = 13; k <= 20; k++) begin
          @(negedge clk);
          check(div_out == 7'(94 + half_off(k)), "R2 resume sequence", div_out, 94 + half_off(k));
        end
      end
    end

    // fractional word above range acts as the top value
    start(20, 5199, 1'b0);
    for (int k = 0; k < 32; k++) begin @(negedge clk); cap[k] = div_out; end
    start(20, 8191, 1'b0);
    for (int k = 0; k < 32; k++) begin
      @(negedge clk);
      check(div_out == 7'(cap[k]), "R10 frac saturation", div_out, cap[k]);
    end

    // dither
    begin
      int diffs;
      diffs = 0;
      start(30, 2600, 1'b1);
      for (int k = 1; k <= 300; k++) begin
        @(negedge clk);
        if (div_out != 7'(94 + half_off(k))) diffs++;
        if (div_out < 7'd64 || div_out > 7'd127)
          check(1'b0, "R11 dither range", div_out, 64);
      end
      check(diffs > 0, "R11 dither changes sequence", diffs, 1);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule